// File: doc/BRIEF.md
# Dual-direction word FIFO with occupancy thresholds

This block sits between a register port and a serial shift engine and buffers 32-bit words in both directions. The transmit path takes words pushed by the register side and hands them to the engine. The receive path takes words pushed by the engine and hands them back to the register side. Each path holds two words, which is eight byte slots, and the block reports its occupancy in bytes. Each path drives its own full, empty, threshold-ready, sticky overflow and sticky underflow flags. These flags appear at fixed bit positions of a status word that a neighbouring control register decodes.

Every data edge uses valid/ready. A producer may raise valid at any time. A word is stored only in a cycle where valid and ready are both high. If valid is high while ready is low, and no flush and no soft reset is in progress, the word is dropped and the overflow flag of that path is set. On the consumer side, valid means a word is available and data shows the head word. If the consumer raises ready while valid is low, outside flush and soft reset, data reads as zero and the underflow flag is set. Ready and valid are always computed from the state at the start of the cycle.

A flush request pulse starts a one-cycle flush that empties both paths and clears their flags. A level soft-reset input does the same for as long as it is held. The threshold for each path is a 3-bit value. With a word width of N bytes, software normally programs N-1 for the receive threshold and 7-N for the transmit threshold.

Top module: `fifo_pair`

## Requirements
- R1: After asynchronous reset, both paths are empty and no overflow or underflow flag is set. flush_busy is 0. Status reads 0x0058, which is both empty bits plus transmit-ready.
- R2: Each path delivers words in arrival order and holds at most two words. The status bits are: transmit full at bit 7, transmit empty at bit 6, receive full at bit 5, receive empty at bit 4. Bits 15:12 and 1:0 read 0. On the producer side, ready is low when the path is full. On the consumer side, valid is low when the path is empty.
- R3: A push offered to a full path is dropped. It sets the overflow flag: transmit at bit 11, receive at bit 9. The flag stays set until a flush or a soft reset.
- R4: A pop from an empty path shows zero data and leaves the path unchanged. It sets the underflow flag: transmit at bit 10, receive at bit 8. The flag stays set until a flush or a soft reset.
- R5: Status bit 2 (receive ready) is 1 exactly when the receive occupancy in bytes (4 per word) is greater than rx_thresh.
- R6: Status bit 3 (transmit ready) is 1 exactly when the free transmit space in bytes (8 minus occupancy) is greater than tx_thresh.
- R7: A flush_req pulse raises flush_busy one cycle later, for exactly one cycle. At the end of that cycle both paths are empty and all four sticky flags are clear. While flush_busy is high, every ready and valid output is low, and pushes and pops have no effect and set no flag.
- R8: While soft_rst is high, every ready and valid output is low, flush_req is ignored, and pushes and pops have no effect. After the first edge with soft_rst high, both paths are empty, all flags are clear and flush_busy is 0.
- R9: A push and a pop in the same cycle both take effect against the start-of-cycle state. On a full path the pop succeeds and the push overflows. On an empty path the pop underflows and the push is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_thresh | input | 3 | Receive ready threshold in bytes |
| tx_thresh | input | 3 | Transmit ready threshold in bytes |
| soft_rst | input | 1 | Level soft reset for both paths |
| flush_req | input | 1 | One-cycle request to flush both paths |
| flush_busy | output | 1 | High while a flush is in progress (self-clearing) |
| status | output | 16 | Flag word, bit positions as in R2 to R6 |
| host_wr_valid | input | 1 | Register side offers a transmit word |
| host_wr_data | input | 32 | Transmit word |
| host_wr_ready | output | 1 | Transmit path accepts a word |
| eng_wr_valid | output | 1 | Transmit word available to the engine |
| eng_wr_data | output | 32 | Head transmit word, zero when not valid |
| eng_wr_ready | input | 1 | Engine takes the transmit word |
| eng_rd_valid | input | 1 | Engine offers a received word |
| eng_rd_data | input | 32 | Received word |
| eng_rd_ready | output | 1 | Receive path accepts a word |
| host_rd_valid | output | 1 | Received word available to the register side |
| host_rd_data | output | 32 | Head received word, zero when not valid |
| host_rd_ready | input | 1 | Register side takes the received word |

## Verification
Any corruption of a path's count or pointers appears at the ports within one clock. It shows up as a wrong full, empty or ready bit, a wrong head word, or a valid or ready that disagrees with the expected occupancy. The bench checks all of these on every cycle. A lost sticky flag shows up in the status word on the edge after the clearing mistake. A flush that runs too long or too short shows up one cycle after the request, as a wrong flush_busy and a blocked or open handshake. A behavioural queue model is compared against every output on every cycle. Directed phases cover the full, empty, flush, soft-reset and simultaneous-operation corners, and a long random phase with changing thresholds follows them.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int STAT_W = 16;
  localparam int THR_W  = 3;

  localparam int ST_WR_OVF   = 11;
  localparam int ST_WR_UDF   = 10;
  localparam int ST_RD_OVF   = 9;
  localparam int ST_RD_UDF   = 8;
  localparam int ST_WR_FULL  = 7;
  localparam int ST_WR_EMPTY = 6;
  localparam int ST_RD_FULL  = 5;
  localparam int ST_RD_EMPTY = 4;
  localparam int ST_WR_RDY   = 3;
  localparam int ST_RD_RDY   = 2;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  typedef struct packed {
    logic full;
    logic empty;
    logic ovf;
    logic udf;
    logic rdy;
  } dir_stat_t;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hold,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic              udf
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign in_ready  = !hold && !full;
  assign out_valid = !hold && !empty;
  assign out_data  = out_valid ? mem[rd_ptr] : '0;
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_ready && out_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (in_valid && !hold && full)   ovf <= 1'b1;
      if (out_ready && !hold && empty) udf <= 1'b1;
    end
  end
endmodule

// File: rtl/thresh_ready.sv
module thresh_ready #(
  parameter int OCC_W      = 4,
  parameter int THR_W      = 3,
  parameter int CAP_BYTES  = 8,
  parameter bit COUNT_FREE = 1'b0
) (
  input  logic [OCC_W-1:0] occ_bytes,
  input  logic [THR_W-1:0] thresh,
  output logic             rdy
);
  logic [OCC_W-1:0] metric;

  generate
    if (COUNT_FREE) begin : g_free
      assign metric = OCC_W'(CAP_BYTES) - occ_bytes;
    end else begin : g_used
      assign metric = occ_bytes;
    end
  endgenerate

  assign rdy = int'(metric) > int'(thresh);
endmodule

// File: rtl/flush_ctl.sv
module flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic flush_req,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (soft_rst) busy <= 1'b0;
    else if (busy)     busy <= 1'b0;
    else               busy <= flush_req;
  end
endmodule

// File: rtl/fifo_pair.sv
module fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int DEPTH_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rx_thresh,
  input  logic [2:0]        tx_thresh,
  input  logic              soft_rst,
  input  logic              flush_req,
  output logic              flush_busy,
  output logic [15:0]       status,
  input  logic              host_wr_valid,
  input  logic [WORD_W-1:0] host_wr_data,
  output logic              host_wr_ready,
  output logic              eng_wr_valid,
  output logic [WORD_W-1:0] eng_wr_data,
  input  logic              eng_wr_ready,
  input  logic              eng_rd_valid,
  input  logic [WORD_W-1:0] eng_rd_data,
  output logic              eng_rd_ready,
  output logic              host_rd_valid,
  output logic [WORD_W-1:0] host_rd_data,
  input  logic              host_rd_ready
);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int CAP_BYTES      = DEPTH_WORDS * BYTES_PER_WORD;
  localparam int OCC_W          = $clog2(CAP_BYTES + 1);
  localparam int CNT_W          = $clog2(DEPTH_WORDS + 1);

  logic              hold_ops;
  logic              busy;
  logic              in_valid  [2];
  logic [WORD_W-1:0] in_data   [2];
  logic              in_ready  [2];
  logic              out_valid [2];
  logic [WORD_W-1:0] out_data  [2];
  logic              out_ready [2];
  logic [CNT_W-1:0]  cnt       [2];
  logic [OCC_W-1:0]  occ       [2];
  logic [THR_W-1:0]  thr       [2];
  dir_stat_t         dstat     [2];

  flush_ctl u_flush (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .flush_req (flush_req),
    .busy      (busy)
  );

  assign hold_ops   = busy || soft_rst;
  assign flush_busy = busy;

  assign in_valid[DIR_TX]  = host_wr_valid;
  assign in_data[DIR_TX]   = host_wr_data;
  assign out_ready[DIR_TX] = eng_wr_ready;
  assign thr[DIR_TX]       = tx_thresh;
  assign in_valid[DIR_RX]  = eng_rd_valid;
  assign in_data[DIR_RX]   = eng_rd_data;
  assign out_ready[DIR_RX] = host_rd_ready;
  assign thr[DIR_RX]       = rx_thresh;

  assign host_wr_ready = in_ready[DIR_TX];
  assign eng_wr_valid  = out_valid[DIR_TX];
  assign eng_wr_data   = out_data[DIR_TX];
  assign eng_rd_ready  = in_ready[DIR_RX];
  assign host_rd_valid = out_valid[DIR_RX];
  assign host_rd_data  = out_data[DIR_RX];

  generate
    for (genvar d = 0; d < 2; d++) begin : g_dir
      word_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH_WORDS)
      ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hold_ops),
        .hold      (hold_ops),
        .in_valid  (in_valid[d]),
        .in_data   (in_data[d]),
        .in_ready  (in_ready[d]),
        .out_valid (out_valid[d]),
        .out_data  (out_data[d]),
        .out_ready (out_ready[d]),
        .count     (cnt[d]),
        .full      (dstat[d].full),
        .empty     (dstat[d].empty),
        .ovf       (dstat[d].ovf),
        .udf       (dstat[d].udf)
      );

      assign occ[d] = OCC_W'(cnt[d] * BYTES_PER_WORD);

      thresh_ready #(
        .OCC_W      (OCC_W),
        .THR_W      (THR_W),
        .CAP_BYTES  (CAP_BYTES),
        .COUNT_FREE (d == DIR_TX)
      ) u_thr (
        .occ_bytes (occ[d]),
        .thresh    (thr[d]),
        .rdy       (dstat[d].rdy)
      );
    end
  endgenerate

  always_comb begin
    status              = '0;
    status[ST_WR_OVF]   = dstat[DIR_TX].ovf;
    status[ST_WR_UDF]   = dstat[DIR_TX].udf;
    status[ST_RD_OVF]   = dstat[DIR_RX].ovf;
    status[ST_RD_UDF]   = dstat[DIR_RX].udf;
    status[ST_WR_FULL]  = dstat[DIR_TX].full;
    status[ST_WR_EMPTY] = dstat[DIR_TX].empty;
    status[ST_RD_FULL]  = dstat[DIR_RX].full;
    status[ST_RD_EMPTY] = dstat[DIR_RX].empty;
    status[ST_WR_RDY]   = dstat[DIR_TX].rdy;
    status[ST_RD_RDY]   = dstat[DIR_RX].rdy;
  end
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              flush_busy,
  input logic [15:0]       status,
  input logic              host_wr_valid,
  input logic              host_wr_ready,
  input logic              eng_wr_valid,
  input logic [WORD_W-1:0] eng_wr_data,
  input logic              host_rd_valid,
  input logic              host_rd_ready,
  input logic [WORD_W-1:0] host_rd_data
);
  // R2: full and empty never together, full blocks the producer
  a_r2_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[6]));
  a_r2_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !host_wr_ready);

  // R3: dropped push raises the flag, which then stays
  a_r3_wr_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && !host_wr_ready && !flush_busy && !soft_rst) |=> status[11]);
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[11] && !flush_busy && !soft_rst) |=> status[11]);

  // R4: empty pops read zero and raise the flag
  a_r4_tx_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_wr_valid |-> (eng_wr_data == '0));
  a_r4_rx_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_valid |-> (host_rd_data == '0));
  a_r4_rd_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_ready && !host_rd_valid && !flush_busy && !soft_rst) |=> status[8]);

  // R7: flush lasts one cycle and leaves everything empty and clear
  a_r7_busy_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> !flush_busy);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (status[6] && status[4] && status[11:8] == 4'h0));

  // R8: soft reset clears state
  a_r8_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!flush_busy && status[6] && status[4] && status[11:8] == 4'h0));
endmodule

bind fifo_pair fifo_pair_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .flush_busy    (flush_busy),
  .status        (status),
  .host_wr_valid (host_wr_valid),
  .host_wr_ready (host_wr_ready),
  .eng_wr_valid  (eng_wr_valid),
  .eng_wr_data   (eng_wr_data),
  .host_rd_valid (host_rd_valid),
  .host_rd_ready (host_rd_ready),
  .host_rd_data  (host_rd_data)
);

// File: tb/tb_fifo_pair.sv
`timescale 1ns/1ps
module tb_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rx_thresh, tx_thresh;
  logic        soft_rst, flush_req;
  logic        flush_busy;
  logic [15:0] status;
  logic        host_wr_valid;
  logic [31:0] host_wr_data;
  logic        host_wr_ready;
  logic        eng_wr_valid;
  logic [31:0] eng_wr_data;
  logic        eng_wr_ready;
  logic        eng_rd_valid;
  logic [31:0] eng_rd_data;
  logic        eng_rd_ready;
  logic        host_rd_valid;
  logic [31:0] host_rd_data;
  logic        host_rd_ready;

  always #2 clk = ~clk;

  fifo_pair dut (
    .clk(clk), .rst_n(rst_n), .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
    .soft_rst(soft_rst), .flush_req(flush_req), .flush_busy(flush_busy),
    .status(status), .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .host_wr_ready(host_wr_ready), .eng_wr_valid(eng_wr_valid),
    .eng_wr_data(eng_wr_data), .eng_wr_ready(eng_wr_ready),
    .eng_rd_valid(eng_rd_valid), .eng_rd_data(eng_rd_data),
    .eng_rd_ready(eng_rd_ready), .host_rd_valid(host_rd_valid),
    .host_rd_data(host_rd_data), .host_rd_ready(host_rd_ready)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] wq[$];
  logic [31:0] rq[$];
  bit m_busy, ovf_w, udf_w, ovf_r, udf_r;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit hold;
    logic [31:0] e_txd, e_rxd;
    logic [15:0] e_fe;
    hold  = m_busy || soft_rst;
    e_txd = (!hold && wq.size() > 0) ? wq[0] : 32'h0;
    e_rxd = (!hold && rq.size() > 0) ? rq[0] : 32'h0;
    e_fe  = 16'h0;
    e_fe[7] = (wq.size() == 2);
    e_fe[6] = (wq.size() == 0);
    e_fe[5] = (rq.size() == 2);
    e_fe[4] = (rq.size() == 0);
    chk("R2", "full/empty bits", {16'h0, status & 16'hF0F3}, {16'h0, e_fe});
    chk("R2", "host_wr_ready", 32'(host_wr_ready), 32'(!hold && wq.size() < 2));
    chk("R2", "eng_rd_ready", 32'(eng_rd_ready), 32'(!hold && rq.size() < 2));
    chk("R2", "eng_wr_valid", 32'(eng_wr_valid), 32'(!hold && wq.size() > 0));
    chk("R2", "host_rd_valid", 32'(host_rd_valid), 32'(!hold && rq.size() > 0));
    chk("R2", "eng_wr_data", eng_wr_data, e_txd);
    chk("R2", "host_rd_data", host_rd_data, e_rxd);
    chk("R3", "overflow bits", 32'({status[11], status[9]}), 32'({ovf_w, ovf_r}));
    chk("R4", "underflow bits", 32'({status[10], status[8]}), 32'({udf_w, udf_r}));
    chk("R5", "rx ready bit", 32'(status[2]), 32'((rq.size() * 4) > int'(rx_thresh)));
    chk("R6", "tx ready bit", 32'(status[3]), 32'((8 - wq.size() * 4) > int'(tx_thresh)));
    chk("R7", "flush_busy", 32'(flush_busy), 32'(m_busy));
  endtask

  task automatic model_clear();
    wq.delete(); rq.delete();
    ovf_w = 0; udf_w = 0; ovf_r = 0; udf_r = 0;
  endtask

  task automatic model_edge();
    int ws, rs;
    if (soft_rst) begin
      model_clear(); m_busy = 0;
    end else if (m_busy) begin
      model_clear(); m_busy = 0;
    end else begin
      ws = wq.size(); rs = rq.size();
      if (host_wr_valid) begin
        if (ws < 2) wq.push_back(host_wr_data); else ovf_w = 1;
      end
      if (eng_wr_ready) begin
        if (ws > 0) void'(wq.pop_front()); else udf_w = 1;
      end
      if (eng_rd_valid) begin
        if (rs < 2) rq.push_back(eng_rd_data); else ovf_r = 1;
      end
      if (host_rd_ready) begin
        if (rs > 0) void'(rq.pop_front()); else udf_r = 1;
      end
      m_busy = flush_req;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    host_wr_valid = 0; eng_wr_ready = 0; eng_rd_valid = 0; host_rd_ready = 0;
    flush_req = 0; soft_rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    rx_thresh = 3'd3; tx_thresh = 3'd3;
    host_wr_data = 0; eng_rd_data = 0;
    m_busy = 0; model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "status after reset", 32'(status), 32'h0058);
    chk("R1", "flush_busy after reset", 32'(flush_busy), 32'h0);
    compare_all();

    // R2/R3: fill transmit path past capacity
    for (int i = 0; i < 3; i++) begin
      host_wr_valid = 1; host_wr_data = 32'hA000_0000 + i; tick();
    end
    host_wr_valid = 0;
    chk("R3", "tx overflow latched", 32'(status[11]), 32'h1);
    // R9: full path, push and pop together -> pop ok, push overflows
    host_wr_valid = 1; host_wr_data = 32'hBEEF_0001; eng_wr_ready = 1; tick();
    host_wr_valid = 0;
    chk("R9", "full push+pop head", eng_wr_data, 32'hA000_0001);
    // R2/R4: drain and underflow
    repeat (2) tick();
    eng_wr_ready = 0;
    chk("R4", "tx underflow latched", 32'(status[10]), 32'h1);

    // receive path: fill, overflow, drain, underflow
    for (int i = 0; i < 3; i++) begin
      eng_rd_valid = 1; eng_rd_data = 32'hC000_0000 + i; tick();
    end
    eng_rd_valid = 0;
    host_rd_ready = 1; repeat (3) tick(); host_rd_ready = 0;
    chk("R4", "rx flags", 32'(status[9:8]), 32'h3);

    // R9: empty path, push and pop together -> underflow, word stored
    flush_req = 1; tick(); flush_req = 0;
    tick();
    host_wr_valid = 1; host_wr_data = 32'h1234_5678; eng_wr_ready = 1; tick();
    host_wr_valid = 0; eng_wr_ready = 0;
    chk("R9", "empty push+pop stores word", eng_wr_data, 32'h1234_5678);

    // R7: flush with traffic during busy cycle
    eng_rd_valid = 1; eng_rd_data = 32'h5555_AAAA; tick(); eng_rd_valid = 0;
    flush_req = 1; tick(); flush_req = 0;
    chk("R7", "busy after request", 32'(flush_busy), 32'h1);
    host_wr_valid = 1; eng_rd_valid = 1; host_rd_ready = 1; eng_wr_ready = 1; tick();
    idle();
    chk("R7", "status after flush", 32'(status), 32'h0058);

    // R5/R6: threshold sweep at each occupancy
    for (int t = 0; t < 8; t++) begin
      rx_thresh = 3'(t); tx_thresh = 3'(7 - t);
      for (int k = 0; k < 2; k++) begin
        host_wr_valid = 1; eng_rd_valid = 1;
        host_wr_data = 32'(t * 16 + k); eng_rd_data = ~32'(t * 16 + k);
        tick();
      end
      idle();
      flush_req = 1; tick(); flush_req = 0; tick();
    end

    // R8: soft reset held with activity and a flush request
    host_wr_valid = 1; eng_rd_valid = 1; tick(); tick(); tick();
    soft_rst = 1; flush_req = 1; eng_wr_ready = 1; host_rd_ready = 1;
    repeat (3) tick();
    idle(); tick();
    chk("R8", "status after soft reset", 32'(status & 16'h0FF0), 32'h0050);
    chk("R8", "no flush after soft reset", 32'(flush_busy), 32'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      host_wr_valid = 1'($urandom_range(0, 1));
      eng_wr_ready  = 1'($urandom_range(0, 1));
      eng_rd_valid  = 1'($urandom_range(0, 1));
      host_rd_ready = 1'($urandom_range(0, 1));
      host_wr_data  = $urandom();
      eng_rd_data   = $urandom();
      flush_req     = ($urandom_range(0, 39) == 0);
      soft_rst      = ($urandom_range(0, 96) == 0);
      if ($urandom_range(0, 63) == 0) begin
        rx_thresh = 3'($urandom_range(0, 7));
        tx_thresh = 3'($urandom_range(0, 7));
      end
      tick();
    end
    idle(); tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule